// File: doc/BRIEF.md
# Vector Element Validation Map

This block tracks, for a core that turns repeating scalar work into speculative vector work, which static instruction owns each live vector register. It also tracks which element of that register the next scalar instance of the instruction has to confirm. Every lookup presents an instruction address with its current renamed source operands and, when one operand is a scalar register, that register's value. The block answers in the same cycle with one of four outcomes: confirm element N of vector register R, spawn a fresh vector instance into a register taken from the free supply, hold the instruction because its scalar operand is not ready yet, or do nothing so the instruction runs as plain scalar code.

Entries sit in a set-associative array indexed by low address bits. An entry records the owning address, the vector register, the element offset, both source operand tags, the scalar value, and, for loads, the inclusive address range the vector covers. A lookup that confirms the last element either moves the entry onto a newly supplied register at offset zero or, if no register is free, marks the entry exhausted. Committing stores are probed against every load entry on two ports per cycle, and a hit drops the entry. A global flush empties the table in one cycle.

Top module: `vrmt_table`

## Requirements
- R1: After reset every lookup misses and reports outcome code 0 (none) with `alloc_take` low.
- R2: A lookup that hits an entry whose recorded operand tags (and scalar value, when `lk_has_scalar` is set) match reports outcome code 1 (confirm). It names the entry's register and the current element offset, and the offset then steps by one, starting at 0 after an install.
- R3: Confirming element VLEN-1 raises `res_roll`. When `free_vld` is high, `alloc_take` also rises, and the entry moves to `free_vreg` at offset 0, so the next matching lookup confirms element 0 of that register.
- R4: If the last element is confirmed while no register is free, the entry becomes exhausted. Later lookups report code 0 while `free_vld` is low and code 2 (spawn) once a register is offered.
- R5: A hit whose operand tags differ from the recorded ones, with a free register offered, reports code 2 with `res_vreg` equal to `free_vreg` and `alloc_take` high. The entry then records the new operands at offset 0.
- R6: A mismatching hit with no free register reports code 0 with `alloc_take` low and leaves the entry unchanged.
- R7: A hit with `lk_has_scalar` high and `lk_scalar_rdy` low reports code 3 (hold), takes no register and changes nothing.
- R8: With the scalar operand ready, a value equal to the recorded one confirms; a different value spawns like R5.
- R9: A store address on either probe port that lies inside a load entry's range, both bounds included, invalidates that entry. Addresses outside the range, and entries not marked as loads, are unaffected.
- R10: `flush_all` invalidates every entry at the next clock edge, taking precedence over an install in the same cycle.
- R11: An install of an address already present overwrites that entry at offset 0. Up to WAYS distinct addresses of one set coexist. Installing into a full set replaces exactly one entry.
- R12: With `lk_valid` low the block reports code 0, takes no register and changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_all | input | 1 | Invalidate every entry |
| lk_valid | input | 1 | Lookup present |
| lk_pc | input | PC_W | Instruction address of the lookup |
| lk_src_a | input | OPD_W | Current renamed first source |
| lk_src_b | input | OPD_W | Current renamed second source |
| lk_has_scalar | input | 1 | One source is a scalar register |
| lk_scalar_rdy | input | 1 | That scalar value is available |
| lk_scalar_val | input | DATA_W | That scalar value |
| lk_rng_lo | input | ADDR_W | Range low bound recorded on spawn/move |
| lk_rng_hi | input | ADDR_W | Range high bound recorded on spawn/move |
| free_vld | input | 1 | A free vector register is offered |
| free_vreg | input | VREG_W | The offered register |
| res_kind | output | 2 | 0 none, 1 confirm, 2 spawn, 3 hold |
| res_vreg | output | VREG_W | Register for confirm or spawn |
| res_elem | output | ELEM_W | Element to confirm |
| res_roll | output | 1 | Last element confirmed |
| alloc_take | output | 1 | Offered register consumed |
| ins_valid | input | 1 | Install an entry |
| ins_pc | input | PC_W | Address of the installed entry |
| ins_vreg | input | VREG_W | Its vector register |
| ins_src_a | input | OPD_W | Its first source tag |
| ins_src_b | input | OPD_W | Its second source tag |
| ins_scalar_val | input | DATA_W | Its scalar value |
| ins_is_load | input | 1 | Entry is a vectorized load |
| ins_rng_lo | input | ADDR_W | Load range low bound |
| ins_rng_hi | input | ADDR_W | Load range high bound |
| st_valid | input | ST_PORTS | Store probe valid per port |
| st_addr | input | ST_PORTS*ADDR_W | Store probe addresses, port 0 in the low bits |

## Verification
The bench builds the table with 4 sets of 2 ways and a vector length of 4. That way a set fills after two installs, and the replacement path of R11 is reached with a handful of addresses that share index bits. A four-element vector lets the roll-over, exhaustion and re-spawn sequences of R3 and R4 complete in a few lookups, and two store ports probe the inclusive range bounds separately.

// File: rtl/vrmt_pkg.sv
package vrmt_pkg;
  typedef enum logic [1:0] {
    RK_NONE  = 2'd0,
    RK_CHECK = 2'd1,
    RK_SPAWN = 2'd2,
    RK_HOLD  = 2'd3
  } res_kind_e;
endpackage

// File: rtl/vrmt_way_match.sv
// Compares one set's ways against a key; also reports the lowest empty way.
module vrmt_way_match #(
  parameter int WAYS  = 4,
  parameter int PC_W  = 32,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]  vld,
  input  logic [PC_W-1:0]  pcs [WAYS],
  input  logic [PC_W-1:0]  key,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way,
  output logic             has_empty,
  output logic [WAY_W-1:0] empty_way
);
  always_comb begin
    hit       = 1'b0;
    hit_way   = '0;
    has_empty = 1'b0;
    empty_way = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (vld[w] && (pcs[w] == key)) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
      end
      if (!vld[w]) begin
        has_empty = 1'b1;
        empty_way = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/vrmt_decide.sv
// Outcome of one lookup against the entry it hit, plus the entry update.
module vrmt_decide
  import vrmt_pkg::*;
#(
  parameter int VLEN   = 4,
  parameter int OFF_W  = 3,
  parameter int ELEM_W = 2,
  parameter int VREG_W = 7,
  parameter int OPD_W  = 8,
  parameter int DATA_W = 64
) (
  input  logic              lk_valid,
  input  logic              hit,
  input  logic [OFF_W-1:0]  e_off,
  input  logic [VREG_W-1:0] e_vreg,
  input  logic [OPD_W-1:0]  e_src_a,
  input  logic [OPD_W-1:0]  e_src_b,
  input  logic [DATA_W-1:0] e_val,
  input  logic [OPD_W-1:0]  lk_src_a,
  input  logic [OPD_W-1:0]  lk_src_b,
  input  logic              lk_has_scalar,
  input  logic              lk_scalar_rdy,
  input  logic [DATA_W-1:0] lk_scalar_val,
  input  logic              free_vld,
  input  logic [VREG_W-1:0] free_vreg,
  output res_kind_e         kind,
  output logic [VREG_W-1:0] vreg,
  output logic [ELEM_W-1:0] elem,
  output logic              roll,
  output logic              take,
  output logic              upd_en,
  output logic [VREG_W-1:0] upd_vreg,
  output logic [OFF_W-1:0]  upd_off
);
  localparam logic [OFF_W-1:0] OFF_END  = OFF_W'(VLEN);
  localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(VLEN-1);

  logic stale;
  logic exhausted;

  assign stale = (lk_src_a != e_src_a) || (lk_src_b != e_src_b) ||
                 (lk_has_scalar && (lk_scalar_val != e_val));
  assign exhausted = (e_off == OFF_END);

  always_comb begin
    kind     = RK_NONE;
    vreg     = e_vreg;
    elem     = '0;
    roll     = 1'b0;
    take     = 1'b0;
    upd_en   = 1'b0;
    upd_vreg = e_vreg;
    upd_off  = e_off;
    if (lk_valid && hit) begin
      if (lk_has_scalar && !lk_scalar_rdy) begin
        kind = RK_HOLD;
      end else if (stale || exhausted) begin
        if (free_vld) begin
          kind     = RK_SPAWN;
          vreg     = free_vreg;
          take     = 1'b1;
          upd_en   = 1'b1;
          upd_vreg = free_vreg;
          upd_off  = '0;
        end
      end else begin
        kind   = RK_CHECK;
        elem   = e_off[ELEM_W-1:0];
        upd_en = 1'b1;
        if (e_off == OFF_LAST) begin
          roll = 1'b1;
          if (free_vld) begin
            take     = 1'b1;
            upd_vreg = free_vreg;
            upd_off  = '0;
          end else begin
            upd_off = OFF_END;
          end
        end else begin
          upd_off = e_off + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vrmt_range_probe.sv
// Checks every load entry's address range against all store probe ports.
module vrmt_range_probe #(
  parameter int NE       = 256,
  parameter int ADDR_W   = 32,
  parameter int ST_PORTS = 2
) (
  input  logic [NE-1:0]              e_vld,
  input  logic [NE-1:0]              e_load,
  input  logic [ADDR_W-1:0]          e_lo [NE],
  input  logic [ADDR_W-1:0]          e_hi [NE],
  input  logic [ST_PORTS-1:0]        st_valid,
  input  logic [ST_PORTS*ADDR_W-1:0] st_addr,
  output logic [NE-1:0]              kill
);
  for (genvar i = 0; i < NE; i++) begin : g_ent
    logic covered;
    always_comb begin
      covered = 1'b0;
      for (int p = 0; p < ST_PORTS; p++) begin
        if (st_valid[p] &&
            (st_addr[p*ADDR_W +: ADDR_W] >= e_lo[i]) &&
            (st_addr[p*ADDR_W +: ADDR_W] <= e_hi[i]))
          covered = 1'b1;
      end
    end
    assign kill[i] = covered && e_vld[i] && e_load[i];
  end
endmodule

// File: rtl/vrmt_table.sv
module vrmt_table
  import vrmt_pkg::*;
#(
  parameter int SETS     = 64,
  parameter int WAYS     = 4,
  parameter int VLEN     = 4,
  parameter int PC_W     = 32,
  parameter int OPD_W    = 8,
  parameter int VREG_W   = 7,
  parameter int DATA_W   = 64,
  parameter int ADDR_W   = 32,
  parameter int ST_PORTS = 2,
  parameter int IDX_LSB  = 2,
  localparam int ELEM_W  = $clog2(VLEN)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush_all,
  input  logic                       lk_valid,
  input  logic [PC_W-1:0]            lk_pc,
  input  logic [OPD_W-1:0]           lk_src_a,
  input  logic [OPD_W-1:0]           lk_src_b,
  input  logic                       lk_has_scalar,
  input  logic                       lk_scalar_rdy,
  input  logic [DATA_W-1:0]          lk_scalar_val,
  input  logic [ADDR_W-1:0]          lk_rng_lo,
  input  logic [ADDR_W-1:0]          lk_rng_hi,
  input  logic                       free_vld,
  input  logic [VREG_W-1:0]          free_vreg,
  output logic [1:0]                 res_kind,
  output logic [VREG_W-1:0]          res_vreg,
  output logic [ELEM_W-1:0]          res_elem,
  output logic                       res_roll,
  output logic                       alloc_take,
  input  logic                       ins_valid,
  input  logic [PC_W-1:0]            ins_pc,
  input  logic [VREG_W-1:0]          ins_vreg,
  input  logic [OPD_W-1:0]           ins_src_a,
  input  logic [OPD_W-1:0]           ins_src_b,
  input  logic [DATA_W-1:0]          ins_scalar_val,
  input  logic                       ins_is_load,
  input  logic [ADDR_W-1:0]          ins_rng_lo,
  input  logic [ADDR_W-1:0]          ins_rng_hi,
  input  logic [ST_PORTS-1:0]        st_valid,
  input  logic [ST_PORTS*ADDR_W-1:0] st_addr
);
  // SETS and WAYS are powers of two, both at least 2; VLEN at least 2.
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int NE    = SETS * WAYS;
  localparam int EID_W = IDX_W + WAY_W;
  localparam int OFF_W = $clog2(VLEN + 1);

  // Entry storage; data fields carry no reset, only the valid bits do.
  logic [NE-1:0]       e_vld;
  logic [NE-1:0]       e_load;
  logic [PC_W-1:0]     e_pc   [NE];
  logic [VREG_W-1:0]   e_vreg [NE];
  logic [OFF_W-1:0]    e_off  [NE];
  logic [OPD_W-1:0]    e_sa   [NE];
  logic [OPD_W-1:0]    e_sb   [NE];
  logic [DATA_W-1:0]   e_val  [NE];
  logic [ADDR_W-1:0]   e_lo   [NE];
  logic [ADDR_W-1:0]   e_hi   [NE];

  // ---------------- lookup path ----------------
  logic [IDX_W-1:0] lk_set;
  logic [WAYS-1:0]  lk_way_vld;
  logic [PC_W-1:0]  lk_way_pc [WAYS];
  logic             lk_hit;
  logic [WAY_W-1:0] lk_way;
  logic             lk_has_empty;
  logic [WAY_W-1:0] lk_empty_way;
  logic [EID_W-1:0] lk_eid;

  assign lk_set = lk_pc[IDX_LSB +: IDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_lk_way
    assign lk_way_vld[w] = e_vld[{lk_set, WAY_W'(w)}];
    assign lk_way_pc[w]  = e_pc[{lk_set, WAY_W'(w)}];
  end

  vrmt_way_match #(.WAYS(WAYS), .PC_W(PC_W), .WAY_W(WAY_W)) u_lk_match (
    .vld       (lk_way_vld),
    .pcs       (lk_way_pc),
    .key       (lk_pc),
    .hit       (lk_hit),
    .hit_way   (lk_way),
    .has_empty (lk_has_empty),
    .empty_way (lk_empty_way)
  );

  assign lk_eid = {lk_set, lk_way};

  res_kind_e         dec_kind;
  logic              dec_take;
  logic              dec_upd;
  logic [VREG_W-1:0] dec_vreg;
  logic [OFF_W-1:0]  dec_off;

  vrmt_decide #(
    .VLEN(VLEN), .OFF_W(OFF_W), .ELEM_W(ELEM_W),
    .VREG_W(VREG_W), .OPD_W(OPD_W), .DATA_W(DATA_W)
  ) u_decide (
    .lk_valid      (lk_valid),
    .hit           (lk_hit),
    .e_off         (e_off[lk_eid]),
    .e_vreg        (e_vreg[lk_eid]),
    .e_src_a       (e_sa[lk_eid]),
    .e_src_b       (e_sb[lk_eid]),
    .e_val         (e_val[lk_eid]),
    .lk_src_a      (lk_src_a),
    .lk_src_b      (lk_src_b),
    .lk_has_scalar (lk_has_scalar),
    .lk_scalar_rdy (lk_scalar_rdy),
    .lk_scalar_val (lk_scalar_val),
    .free_vld      (free_vld),
    .free_vreg     (free_vreg),
    .kind          (dec_kind),
    .vreg          (res_vreg),
    .elem          (res_elem),
    .roll          (res_roll),
    .take          (dec_take),
    .upd_en        (dec_upd),
    .upd_vreg      (dec_vreg),
    .upd_off       (dec_off)
  );

  assign res_kind   = dec_kind;
  assign alloc_take = dec_take;

  // ---------------- install path ----------------
  logic [IDX_W-1:0] in_set;
  logic [WAYS-1:0]  in_way_vld;
  logic [PC_W-1:0]  in_way_pc [WAYS];
  logic             in_hit;
  logic [WAY_W-1:0] in_hit_way;
  logic             in_has_empty;
  logic [WAY_W-1:0] in_empty_way;
  logic [WAY_W-1:0] in_way;
  logic [EID_W-1:0] in_eid;
  logic [WAY_W-1:0] rr_q;
  logic [WAY_W-1:0] rr_d;

  assign in_set = ins_pc[IDX_LSB +: IDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_in_way
    assign in_way_vld[w] = e_vld[{in_set, WAY_W'(w)}];
    assign in_way_pc[w]  = e_pc[{in_set, WAY_W'(w)}];
  end

  vrmt_way_match #(.WAYS(WAYS), .PC_W(PC_W), .WAY_W(WAY_W)) u_in_match (
    .vld       (in_way_vld),
    .pcs       (in_way_pc),
    .key       (ins_pc),
    .hit       (in_hit),
    .hit_way   (in_hit_way),
    .has_empty (in_has_empty),
    .empty_way (in_empty_way)
  );

  // Reuse a matching way, else an empty way, else the rotating victim.
  always_comb begin
    if (in_hit)            in_way = in_hit_way;
    else if (in_has_empty) in_way = in_empty_way;
    else                   in_way = rr_q;
  end
  assign in_eid = {in_set, in_way};

  always_comb begin
    rr_d = rr_q;
    if (ins_valid && !flush_all && !in_hit && !in_has_empty)
      rr_d = rr_q + 1'b1;
  end

  // ---------------- store probe ----------------
  logic [NE-1:0] kill;

  vrmt_range_probe #(.NE(NE), .ADDR_W(ADDR_W), .ST_PORTS(ST_PORTS)) u_probe (
    .e_vld    (e_vld),
    .e_load   (e_load),
    .e_lo     (e_lo),
    .e_hi     (e_hi),
    .st_valid (st_valid),
    .st_addr  (st_addr),
    .kill     (kill)
  );

  // ---------------- valid next state ----------------
  // Order of precedence: flush, then install, then store kill.
  logic [NE-1:0] vld_d;

  always_comb begin
    vld_d = e_vld & ~kill;
    if (ins_valid) vld_d[in_eid] = 1'b1;
    if (flush_all) vld_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_vld <= '0;
      rr_q  <= '0;
    end else begin
      e_vld <= vld_d;
      rr_q  <= rr_d;
    end
  end

  // ---------------- entry data ----------------
  logic lk_we;
  assign lk_we = dec_upd && !flush_all;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NE; i++) begin
      if (ins_valid && (in_eid == EID_W'(i))) begin
        e_pc[i]   <= ins_pc;
        e_vreg[i] <= ins_vreg;
        e_off[i]  <= '0;
        e_sa[i]   <= ins_src_a;
        e_sb[i]   <= ins_src_b;
        e_val[i]  <= ins_scalar_val;
        e_load[i] <= ins_is_load;
        e_lo[i]   <= ins_rng_lo;
        e_hi[i]   <= ins_rng_hi;
      end else if (lk_we && (lk_eid == EID_W'(i))) begin
        e_vreg[i] <= dec_vreg;
        e_off[i]  <= dec_off;
        if (dec_take) begin
          e_sa[i]  <= lk_src_a;
          e_sb[i]  <= lk_src_b;
          e_val[i] <= lk_scalar_val;
          e_lo[i]  <= lk_rng_lo;
          e_hi[i]  <= lk_rng_hi;
        end
      end
    end
  end
endmodule

// File: rtl/vrmt_chk.sv
module vrmt_chk #(
  parameter int VLEN   = 4,
  parameter int VREG_W = 7,
  localparam int EW    = $clog2(VLEN)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush_all,
  input logic              lk_valid,
  input logic              lk_has_scalar,
  input logic              lk_scalar_rdy,
  input logic              free_vld,
  input logic [VREG_W-1:0] free_vreg,
  input logic [1:0]        res_kind,
  input logic [VREG_W-1:0] res_vreg,
  input logic [EW-1:0]     res_elem,
  input logic              res_roll,
  input logic              alloc_take
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (res_kind == 2'd0) && !alloc_take); // R12
  AST_TAKE_NEEDS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_take |-> free_vld); // R6
  AST_SPAWN_USES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_kind == 2'd2) |-> alloc_take && (res_vreg == free_vreg)); // R5
  AST_ROLL_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    res_roll |-> (res_kind == 2'd1) && (res_elem == EW'(VLEN-1))); // R3
  AST_HOLD_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_kind == 2'd3) |-> lk_has_scalar && !lk_scalar_rdy && !alloc_take); // R7
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (res_kind == 2'd0) && !alloc_take); // R10
endmodule

bind vrmt_table vrmt_chk #(.VLEN(VLEN), .VREG_W(VREG_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .flush_all     (flush_all),
  .lk_valid      (lk_valid),
  .lk_has_scalar (lk_has_scalar),
  .lk_scalar_rdy (lk_scalar_rdy),
  .free_vld      (free_vld),
  .free_vreg     (free_vreg),
  .res_kind      (res_kind),
  .res_vreg      (res_vreg),
  .res_elem      (res_elem),
  .res_roll      (res_roll),
  .alloc_take    (alloc_take)
);

// File: tb/sim_vrmt_table.sv
`timescale 1ns/1ps
module sim_vrmt_table;
  localparam int SETS = 4, WAYS = 2, VLEN = 4, PC_W = 16, OPD_W = 6;
  localparam int VREG_W = 5, DATA_W = 16, ADDR_W = 16, ST_PORTS = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic flush_all = 0, lk_valid = 0, lk_has_scalar = 0, lk_scalar_rdy = 0, free_vld = 0;
  logic [PC_W-1:0] lk_pc = '0;
  logic [OPD_W-1:0] lk_src_a = '0, lk_src_b = '0;
  logic [DATA_W-1:0] lk_scalar_val = '0;
  logic [ADDR_W-1:0] lk_rng_lo = '0, lk_rng_hi = '0;
  logic [VREG_W-1:0] free_vreg = '0;
  logic [1:0] res_kind;
  logic [VREG_W-1:0] res_vreg;
  logic [1:0] res_elem;
  logic res_roll, alloc_take;
  logic ins_valid = 0, ins_is_load = 0;
  logic [PC_W-1:0] ins_pc = '0;
  logic [VREG_W-1:0] ins_vreg = '0;
  logic [OPD_W-1:0] ins_src_a = '0, ins_src_b = '0;
  logic [DATA_W-1:0] ins_scalar_val = '0;
  logic [ADDR_W-1:0] ins_rng_lo = '0, ins_rng_hi = '0;
  logic [ST_PORTS-1:0] st_valid = '0;
  logic [ST_PORTS*ADDR_W-1:0] st_addr = '0;

  vrmt_table #(
    .SETS(SETS), .WAYS(WAYS), .VLEN(VLEN), .PC_W(PC_W), .OPD_W(OPD_W),
    .VREG_W(VREG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ST_PORTS(ST_PORTS), .IDX_LSB(2)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .flush_all(flush_all),
    .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_src_a(lk_src_a), .lk_src_b(lk_src_b),
    .lk_has_scalar(lk_has_scalar), .lk_scalar_rdy(lk_scalar_rdy), .lk_scalar_val(lk_scalar_val),
    .lk_rng_lo(lk_rng_lo), .lk_rng_hi(lk_rng_hi), .free_vld(free_vld), .free_vreg(free_vreg),
    .res_kind(res_kind), .res_vreg(res_vreg), .res_elem(res_elem), .res_roll(res_roll),
    .alloc_take(alloc_take), .ins_valid(ins_valid), .ins_pc(ins_pc), .ins_vreg(ins_vreg),
    .ins_src_a(ins_src_a), .ins_src_b(ins_src_b), .ins_scalar_val(ins_scalar_val),
    .ins_is_load(ins_is_load), .ins_rng_lo(ins_rng_lo), .ins_rng_hi(ins_rng_hi),
    .st_valid(st_valid), .st_addr(st_addr)
  );

  int n_run = 0, n_fail = 0;
  logic [1:0] g_kind;
  logic [VREG_W-1:0] g_vreg;
  logic [1:0] g_elem;
  logic g_roll, g_take;

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Drive a lookup at the falling edge, capture the combinational answer,
  // let the rising edge commit it, then drop the request.
  task automatic lookup(input logic [PC_W-1:0] pc, input logic [OPD_W-1:0] sa,
                        input logic [OPD_W-1:0] sb, input logic hs, input logic rdy,
                        input logic [DATA_W-1:0] val, input logic fv,
                        input logic [VREG_W-1:0] fr);
    @(negedge clk);
    lk_valid = 1; lk_pc = pc; lk_src_a = sa; lk_src_b = sb;
    lk_has_scalar = hs; lk_scalar_rdy = rdy; lk_scalar_val = val;
    free_vld = fv; free_vreg = fr; lk_rng_lo = 16'h0200; lk_rng_hi = 16'h021C;
    #1;
    g_kind = res_kind; g_vreg = res_vreg; g_elem = res_elem;
    g_roll = res_roll; g_take = alloc_take;
    @(posedge clk);
    #1;
    lk_valid = 0; free_vld = 0; lk_has_scalar = 0;
  endtask

  task automatic install(input logic [PC_W-1:0] pc, input logic [VREG_W-1:0] vr,
                         input logic [OPD_W-1:0] sa, input logic [OPD_W-1:0] sb,
                         input logic [DATA_W-1:0] val, input logic ld,
                         input logic [ADDR_W-1:0] lo, input logic [ADDR_W-1:0] hi);
    @(negedge clk);
    ins_valid = 1; ins_pc = pc; ins_vreg = vr; ins_src_a = sa; ins_src_b = sb;
    ins_scalar_val = val; ins_is_load = ld; ins_rng_lo = lo; ins_rng_hi = hi;
    @(posedge clk);
    #1 ins_valid = 0;
  endtask

  task automatic store(input logic [1:0] v, input logic [ADDR_W-1:0] a0,
                       input logic [ADDR_W-1:0] a1);
    @(negedge clk);
    st_valid = v; st_addr = {a1, a0};
    @(posedge clk);
    #1 st_valid = '0;
  endtask

  typedef struct packed {
    logic [15:0] pc; logic [5:0] sa; logic [5:0] sb; logic fv; logic [4:0] fr;
    logic [1:0] k; logic [4:0] vr; logic [1:0] el; logic roll; logic take;
  } step_t;

  localparam logic [15:0] PA = 16'h0010, PD = 16'h0014, PE = 16'h0020;
  localparam logic [15:0] PF = 16'h0030, PL = 16'h0044;

  localparam step_t STEPS [15] = '{
    '{PA, 6'd1, 6'd2, 1'b1, 5'd9,  2'd1, 5'd3,  2'd0, 1'b0, 1'b0},
    '{PA, 6'd1, 6'd2, 1'b1, 5'd9,  2'd1, 5'd3,  2'd1, 1'b0, 1'b0},
    '{PA, 6'd1, 6'd2, 1'b1, 5'd9,  2'd1, 5'd3,  2'd2, 1'b0, 1'b0},
    '{PA, 6'd1, 6'd2, 1'b1, 5'd9,  2'd1, 5'd3,  2'd3, 1'b1, 1'b1},
    '{PA, 6'd1, 6'd2, 1'b0, 5'd0,  2'd1, 5'd9,  2'd0, 1'b0, 1'b0},
    '{PA, 6'd5, 6'd2, 1'b1, 5'd12, 2'd2, 5'd12, 2'd0, 1'b0, 1'b1},
    '{PA, 6'd5, 6'd2, 1'b0, 5'd0,  2'd1, 5'd12, 2'd0, 1'b0, 1'b0},
    '{PA, 6'd1, 6'd2, 1'b0, 5'd0,  2'd0, 5'd0,  2'd0, 1'b0, 1'b0},
    '{PA, 6'd5, 6'd2, 1'b0, 5'd0,  2'd1, 5'd12, 2'd1, 1'b0, 1'b0},
    '{PA, 6'd5, 6'd2, 1'b0, 5'd0,  2'd1, 5'd12, 2'd2, 1'b0, 1'b0},
    '{PA, 6'd5, 6'd2, 1'b0, 5'd0,  2'd1, 5'd12, 2'd3, 1'b1, 1'b0},
    '{PA, 6'd5, 6'd2, 1'b0, 5'd0,  2'd0, 5'd0,  2'd0, 1'b0, 1'b0},
    '{PA, 6'd5, 6'd2, 1'b1, 5'd7,  2'd2, 5'd7,  2'd0, 1'b0, 1'b1},
    '{PA, 6'd5, 6'd2, 1'b0, 5'd0,  2'd1, 5'd7,  2'd0, 1'b0, 1'b0},
    '{PD, 6'd1, 6'd2, 1'b1, 5'd9,  2'd0, 5'd0,  2'd0, 1'b0, 1'b0}
  };

  function automatic string row_tag(input int r);
    case (r)
      3, 10:     return "R3 roll";
      11, 12:    return "R4 exhausted";
      5:         return "R5 operand change";
      7:         return "R6 no free register";
      14:        return "R1 miss";
      default:   return "R2 confirm";
    endcase
  endfunction

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int misses;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: empty after reset
    #1;
    check("R1 idle kind", int'(res_kind), 0);
    lookup(PA, 1, 2, 0, 0, 0, 1, 9);
    check("R1 reset miss kind", int'(g_kind), 0);
    check("R1 reset miss take", int'(g_take), 0);

    install(PA, 3, 1, 2, 0, 0, 0, 0);
    for (int r = 0; r < 15; r++) begin
      lookup(STEPS[r].pc, STEPS[r].sa, STEPS[r].sb, 0, 0, 0, STEPS[r].fv, STEPS[r].fr);
      check({row_tag(r), " kind"}, int'(g_kind), int'(STEPS[r].k));
      check({row_tag(r), " take"}, int'(g_take), int'(STEPS[r].take));
      check({row_tag(r), " roll"}, int'(g_roll), int'(STEPS[r].roll));
      if (STEPS[r].k != 2'd0)
        check({row_tag(r), " vreg"}, int'(g_vreg), int'(STEPS[r].vr));
      if (STEPS[r].k == 2'd1)
        check({row_tag(r), " elem"}, int'(g_elem), int'(STEPS[r].el));
    end

    // R12: an idle cycle with a register offered changes nothing
    @(negedge clk);
    free_vld = 1; free_vreg = 5'd30; lk_pc = PA; lk_src_a = 6'd9;
    #1;
    check("R12 idle kind", int'(res_kind), 0);
    check("R12 idle take", int'(alloc_take), 0);
    @(posedge clk);
    #1 free_vld = 0;
    lookup(PA, 5, 2, 0, 0, 0, 0, 0);
    check("R12 entry kept vreg", int'(g_vreg), 7);
    check("R12 entry kept elem", int'(g_elem), 1);

    // R7 / R8: scalar operand
    install(PE, 4, 1, 2, 16'h0055, 0, 0, 0);
    lookup(PE, 1, 2, 1, 0, 16'h0055, 1, 11);
    check("R7 hold kind", int'(g_kind), 3);
    check("R7 hold take", int'(g_take), 0);
    lookup(PE, 1, 2, 1, 1, 16'h0055, 0, 0);
    check("R7 R8 match kind", int'(g_kind), 1);
    check("R7 unchanged elem", int'(g_elem), 0);
    check("R8 match vreg", int'(g_vreg), 4);
    lookup(PE, 1, 2, 1, 1, 16'h0066, 1, 11);
    check("R8 value change kind", int'(g_kind), 2);
    check("R8 value change vreg", int'(g_vreg), 11);
    lookup(PE, 1, 2, 1, 1, 16'h0066, 0, 0);
    check("R8 new value confirm", int'(g_kind), 1);
    check("R8 new value elem", int'(g_elem), 0);

    // R11: reinstall overwrites; two ways of one set coexist
    install(PA, 20, 1, 2, 0, 0, 0, 0);
    lookup(PA, 1, 2, 0, 0, 0, 0, 0);
    check("R11 overwrite vreg", int'(g_vreg), 20);
    check("R11 overwrite elem", int'(g_elem), 0);
    lookup(PE, 1, 2, 1, 1, 16'h0066, 0, 0);
    check("R11 coexist kind", int'(g_kind), 1);
    check("R11 coexist elem", int'(g_elem), 1);
    install(PF, 21, 1, 2, 0, 0, 0, 0);
    lookup(PF, 1, 2, 0, 0, 0, 0, 0);
    check("R11 new entry kind", int'(g_kind), 1);
    check("R11 new entry vreg", int'(g_vreg), 21);
    misses = 0;
    lookup(PA, 1, 2, 0, 0, 0, 0, 0);
    if (g_kind == 2'd0) misses++;
    lookup(PE, 1, 2, 1, 1, 16'h0066, 0, 0);
    if (g_kind == 2'd0) misses++;
    check("R11 exactly one victim", misses, 1);

    // R9: store range probe
    install(PL, 6, 1, 2, 0, 1, 16'h0100, 16'h011C);
    store(2'b11, 16'h011D, 16'h00FC);
    lookup(PL, 1, 2, 0, 0, 0, 0, 0);
    check("R9 outside range kept", int'(g_kind), 1);
    check("R9 outside range vreg", int'(g_vreg), 6);
    store(2'b01, 16'h011C, 16'h0000);
    lookup(PL, 1, 2, 0, 0, 0, 0, 0);
    check("R9 high bound port0 kills", int'(g_kind), 0);
    install(PL, 6, 1, 2, 0, 1, 16'h0100, 16'h011C);
    store(2'b10, 16'h0000, 16'h0100);
    lookup(PL, 1, 2, 0, 0, 0, 0, 0);
    check("R9 low bound port1 kills", int'(g_kind), 0);
    install(PD, 8, 1, 2, 0, 0, 16'h0100, 16'h011C);
    store(2'b01, 16'h0100, 16'h0000);
    lookup(PD, 1, 2, 0, 0, 0, 0, 0);
    check("R9 non-load kept", int'(g_kind), 1);
    check("R9 non-load vreg", int'(g_vreg), 8);

    // R10: flush wins over a same-cycle install
    @(negedge clk);
    flush_all = 1; ins_valid = 1; ins_pc = PL; ins_vreg = 5'd2;
    ins_src_a = 6'd1; ins_src_b = 6'd2; ins_is_load = 0;
    @(posedge clk);
    #1 flush_all = 0; ins_valid = 0;
    lookup(PD, 1, 2, 0, 0, 0, 1, 3);
    check("R10 flushed D", int'(g_kind), 0);
    lookup(PF, 1, 2, 0, 0, 0, 1, 3);
    check("R10 flushed F", int'(g_kind), 0);
    lookup(PL, 1, 2, 0, 0, 0, 1, 3);
    check("R10 install dropped", int'(g_kind), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule